// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Gating

This block holds the return addresses of a small microcontroller core in a dedicated stack that software cannot read or write. A subroutine call, or an interrupt acknowledge that the block itself issues, stores the current program counter. A return of either kind removes the newest entry. The entry on top of the stack is always shown at the return-address output, and the core loads it when it executes a return.

The stack is a circular buffer with a saturating occupancy count. An interrupt request sets a pending flag, which stays set until the request is acknowledged. The block withholds the acknowledge while the stack is full, and also in any cycle that carries a call or a return. A withheld interrupt is therefore taken in the first free cycle after a return has released a level. When a call arrives while the stack is full, the write index wraps and the oldest entry is overwritten, so the newest DEPTH addresses remain.

Top module: `return_addr_stack`

## Requirements
- R1: After reset the stack is empty, the pending flag and the acknowledge are low, and the return-address output is zero.
- R2: A call stores pc_i on the stack. From the next cycle the return-address output shows that value.
- R3: A return on a non-empty stack removes the top entry. From the next cycle the output shows the entry that was pushed before it (last in, first out).
- R4: A cycle with irq_req_i high sets the pending flag for the next cycle. The flag stays high until a cycle in which irq_ack_o is high and no new request arrives.
- R5: irq_ack_o is high in a cycle exactly when the flag is set, irq_en_i is high, the stack is not full, and neither call_i nor ret_i is high. That same cycle pushes pc_i.
- R6: While the stack holds DEPTH entries, irq_ack_o stays low even with the flag set and irq_en_i high, and the flag stays set.
- R7: A return on a full stack with an interrupt pending and enabled is followed in the next cycle by irq_ack_o.
- R8: A call on a full stack overwrites the oldest entry and the stack stays full. Later returns give back the newest DEPTH addresses, newest first.
- R9: A return on an empty stack changes nothing. The output holds its value and a following call behaves as on an empty stack.
- R10: When a call and a pending, enabled interrupt fall in the same cycle, the call is pushed. The acknowledge follows in the next cycle that has no call and no return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| call_i | input | 1 | Subroutine call: push pc_i |
| ret_i | input | 1 | Return or return-from-interrupt: pop |
| irq_req_i | input | 1 | Interrupt request pulse |
| irq_en_i | input | 1 | Interrupt enable |
| pc_i | input | ADDR_W | Program counter value to push |
| ret_addr_o | output | ADDR_W | Entry on top of the stack |
| irq_flag_o | output | 1 | Pending interrupt flag |
| irq_ack_o | output | 1 | Interrupt acknowledge (also pushes pc_i) |

## Verification
The assertions assume that call_i and ret_i are never high in the same cycle, because the core issues at most one control transfer per cycle. The bench builds every cycle with either a call, a return, or neither, and never both. It biases the random choices so that the stack often runs full and often runs empty, which exercises the overflow, the withheld-acknowledge case and the empty-return case under mixed request and enable patterns.

// File: rtl/ras_pkg.sv
package ras_pkg;
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned depth);
    return (v == depth - 1) ? 0 : v + 1;
  endfunction

  function automatic int unsigned wrap_dec(int unsigned v, int unsigned depth);
    return (v == 0) ? depth - 1 : v - 1;
  endfunction
endpackage

// File: rtl/ras_ptr.sv
module ras_ptr #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] top_idx,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  import ras_pkg::*;

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign wr_idx  = idx_q;
  assign top_idx = IDX_W'(wrap_dec(int'(idx_q), DEPTH));
  assign count   = cnt_q;

  always_comb begin
    idx_d = idx_q;
    cnt_d = cnt_q;
    if (push) begin
      idx_d = IDX_W'(wrap_inc(int'(idx_q), DEPTH));
      if (!full) cnt_d = cnt_q + 1'b1;
    end else if (pop && !empty) begin
      idx_d = top_idx;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (push || pop) begin
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 13,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  logic [ADDR_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = we && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic en,
  input  logic full,
  input  logic call,
  input  logic ret,
  output logic flag,
  output logic ack
);
  logic flag_q, flag_d;

  assign ack    = flag_q && en && !full && !call && !ret;
  assign flag_d = (flag_q && !ack) || req;
  assign flag   = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/return_addr_stack.sv
module return_addr_stack #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              irq_req_i,
  input  logic              irq_en_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              irq_flag_o,
  output logic              irq_ack_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] wr_idx, top_idx;
  logic [CNT_W-1:0] count;
  logic             full, push;

  assign push = call_i || irq_ack_o;

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(ret_i),
    .wr_idx(wr_idx), .top_idx(top_idx), .count(count), .full(full)
  );

  ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(push), .wr_idx(wr_idx), .wr_data(pc_i),
    .rd_idx(top_idx), .rd_data(ret_addr_o)
  );

  ras_irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .req(irq_req_i), .en(irq_en_i), .full(full),
    .call(call_i), .ret(ret_i), .flag(irq_flag_o), .ack(irq_ack_o)
  );
endmodule

// File: rtl/return_addr_stack_chk.sv
module return_addr_stack_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 13,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_i,
  input logic              ret_i,
  input logic              irq_req_i,
  input logic              irq_en_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] ret_addr_o,
  input logic              irq_flag_o,
  input logic              irq_ack_o,
  input logic [CNT_W-1:0]  count
);
  logic full_c;
  assign full_c = (count == CNT_W'(DEPTH));

  AST_ONE_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n) !(call_i && ret_i)); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count <= CNT_W'(DEPTH)); // R8
  AST_PUSH_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i || irq_ack_o) |=> ret_addr_o == $past(pc_i)); // R2
  AST_ACK_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> (irq_flag_o && irq_en_i)); // R5
  AST_NO_ACK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full_c |-> !irq_ack_o); // R6
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag_o && !irq_ack_o) |=> irq_flag_o); // R4
  AST_FULL_CALL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_c && call_i) |=> full_c); // R8
  AST_EMPTY_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && count == '0) |=> (count == '0 && $stable(ret_addr_o))); // R9
  AST_CALL_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |-> !irq_ack_o); // R10
endmodule

bind return_addr_stack return_addr_stack_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .irq_req_i(irq_req_i),
  .irq_en_i(irq_en_i), .pc_i(pc_i), .ret_addr_o(ret_addr_o), .irq_flag_o(irq_flag_o),
  .irq_ack_o(irq_ack_o), .count(count)
);

// File: tb/return_addr_stack_tb.sv
module return_addr_stack_tb;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_i = 1'b0, ret_i = 1'b0, irq_req_i = 1'b0, irq_en_i = 1'b0;
  logic [ADDR_W-1:0] pc_i = '0;
  logic [ADDR_W-1:0] ret_addr_o;
  logic irq_flag_o, irq_ack_o;

  int n_chk = 0, n_bad = 0;

  logic [ADDR_W-1:0] m_mem [DEPTH];
  int m_idx = 0, m_cnt = 0;
  bit m_flag = 1'b0;

  always #2.5 clk = ~clk;

  return_addr_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .irq_req_i(irq_req_i),
    .irq_en_i(irq_en_i), .pc_i(pc_i), .ret_addr_o(ret_addr_o),
    .irq_flag_o(irq_flag_o), .irq_ack_o(irq_ack_o)
  );

  function automatic int dec_i(int v);
    return (v == 0) ? DEPTH - 1 : v - 1;
  endfunction

  function automatic bit exp_ack(bit c, bit r, bit en);
    return m_flag && en && (m_cnt < DEPTH) && !c && !r;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare settled outputs, update model at posedge.
  task automatic step(bit c, bit r, bit q, bit en, logic [ADDR_W-1:0] pc, string tag);
    bit a;
    call_i = c; ret_i = r; irq_req_i = q; irq_en_i = en; pc_i = pc;
    #1;
    a = exp_ack(c, r, en);
    check({tag, " ack"}, int'(irq_ack_o), int'(a));
    check({tag, " flag"}, int'(irq_flag_o), int'(m_flag));
    check({tag, " top"}, int'(ret_addr_o), int'(m_mem[dec_i(m_idx)]));
    @(posedge clk);
    if (c || a) begin
      m_mem[m_idx] = pc;
      m_idx = (m_idx == DEPTH - 1) ? 0 : m_idx + 1;
      if (m_cnt < DEPTH) m_cnt++;
    end else if (r && m_cnt > 0) begin
      m_idx = dec_i(m_idx);
      m_cnt--;
    end
    m_flag = (m_flag && !a) || q;
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 top", int'(ret_addr_o), 0);
    check("R1 flag", int'(irq_flag_o), 0);
    check("R1 ack", int'(irq_ack_o), 0);

    // R9: return on empty stack
    step(0, 1, 0, 0, 13'h0, "R9");
    step(0, 0, 0, 0, 13'h0, "R9");
    // R2: fill the stack
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, ADDR_W'(13'h100 + i), "R2");
    // R6: request while full, enabled
    step(0, 0, 1, 1, 13'h0, "R6");
    step(0, 0, 0, 1, 13'h0, "R6");
    step(0, 0, 0, 1, 13'h0, "R6");
    // R8: overflow calls while pending but disabled
    step(1, 0, 0, 0, 13'h1AA, "R8");
    step(1, 0, 0, 0, 13'h1BB, "R8");
    // R7: return frees a level, acknowledge follows
    step(0, 1, 0, 1, 13'h0, "R7");
    step(0, 0, 0, 1, 13'h777, "R7");
    step(0, 0, 0, 0, 13'h0, "R7");
    // R3: drain, including the overflowed entries
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 0, 0, 13'h0, "R3");
    step(0, 1, 0, 0, 13'h0, "R9");
    step(1, 0, 0, 0, 13'h055, "R9");
    // R10: call coinciding with a pending enabled interrupt
    step(0, 0, 1, 0, 13'h0, "R10");
    step(1, 0, 0, 1, 13'h0AA, "R10");
    step(0, 0, 0, 1, 13'h0BB, "R10");
    step(0, 1, 0, 1, 13'h0, "R10");
    // R4: flag held while disabled, new request during acknowledge
    step(0, 0, 1, 0, 13'h0, "R4");
    step(0, 0, 0, 0, 13'h0, "R4");
    step(0, 0, 1, 1, 13'h321, "R4");
    step(0, 0, 0, 0, 13'h0, "R4");

    // R5: random mix
    for (int n = 0; n < 3000; n++) begin
      int sel;
      bit c, r;
      sel = int'($urandom_range(0, 9));
      c = (n % 400 < 200) ? (sel < 5) : (sel < 2);
      r = !c && ((n % 400 < 200) ? (sel >= 8) : (sel >= 5));
      step(c, r, ($urandom_range(0, 5) == 0), ($urandom_range(0, 2) != 0),
           ADDR_W'($urandom), "R5");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule